// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter with End Flags

This block decides which DMA channel owns the shared system bus, and it keeps an end-of-transfer flag for each channel. Each channel has a request line, a transfer mode and three control bits that software writes: enable, active and interrupt-enable. The datapath reports the end of each bus cycle to the block. It also reports when a channel's total count has run out and when a block boundary has been reached. From these inputs the block registers a single bus owner, which is channel 0, channel 1 or an external non-DMA master.

Priority is fixed, and the lower channel index wins a simultaneous request. Ownership changes only at a release point. A channel in single mode releases the bus after every bus cycle. A channel in block mode releases it at a block boundary. A channel in burst mode releases it only when it finishes or is stopped. At a release, a waiting channel other than the outgoing one is preferred over the outgoing one. A pending external master is given exactly one cycle before the next channel starts. A channel's end flag is set in two cases: when its count is exhausted, or when software stops it after the bus cycle in progress. The flag, gated by the interrupt-enable bit, forms the interrupt request. Writing a resume to the channel clears both.

Top module: `dma2_arbiter`

## Requirements
- R1: When the bus is free and both channels are eligible with no earlier owner to exclude, channel 0 is granted (gnt_o = 2'b01).
- R2: At a release, the highest-priority eligible channel other than the outgoing one is granted. The outgoing channel is granted again only if no other channel is eligible.
- R3: If ext_req_i is high at a release point, ext_gnt_o is asserted for exactly one cycle with gnt_o = 0, and the next channel is granted in the following cycle.
- R4: A channel in burst mode (2'b01) or block mode (2'b10) keeps the grant across bus cycles. A burst releases only at count end or stop. A block also releases when blk_end_i is high together with cyc_done_i.
- R5: cyc_done_i and cnt_done_i high together for the owning channel set that channel's end flag at the next edge, and the bus is released.
- R6: irq_o[k] is 1 exactly when the end flag of channel k and its interrupt-enable bit are both 1.
- R7: A write with cfg_act_i = 0 to the owning channel sets its end flag only at the edge that ends its current bus cycle. The flag stays 0 until then.
- R8: A write with cfg_en_i = 1 and cfg_act_i = 1 (resume) clears the channel's end flag and interrupt request at the next edge.
- R9: Single mode (2'b00, and 2'b11 treated the same) releases the bus after every bus cycle of the owner.
- R10: At most one of gnt_o[0], gnt_o[1] and ext_gnt_o is high at any time, and a grant changes only at a clock edge that is a release point.
- R11: A channel with its enable bit or active bit at 0, or with its end flag set, is never granted.
- R12: After reset, no grant is asserted and all end flags and interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Transfer request per channel |
| mode_i | input | 4 | Transfer mode per channel, 2 bits each (00 single, 01 burst, 10 block) |
| ext_req_i | input | 1 | Bus request from the external non-DMA master |
| cyc_done_i | input | 2 | Current bus cycle of the channel has finished |
| cnt_done_i | input | 2 | Total count exhausted; qualified by cyc_done_i |
| blk_end_i | input | 2 | Block boundary reached; qualified by cyc_done_i |
| cfg_we_i | input | 2 | Control-bit write strobe per channel |
| cfg_en_i | input | 2 | Enable bit value written |
| cfg_act_i | input | 2 | Active bit value written |
| cfg_ie_i | input | 2 | Interrupt-enable bit value written |
| gnt_o | output | 2 | One-hot channel grant |
| ext_gnt_o | output | 1 | External master grant |
| end_flag_o | output | 2 | End-of-transfer flag per channel |
| irq_o | output | 2 | Transfer-end interrupt request per channel |

## Verification
The assertions assume the following about the inputs. Only the owning channel raises cyc_done_i. cnt_done_i and blk_end_i count only in the cycle where cyc_done_i is also high. The external master needs no more than one cycle per grant. The stimulus respects these rules: strobes go only to the channel that the bench's expected grant names, and each strobe lasts exactly one cycle. A stop is written only while the target channel owns the bus, or while it is idle, and never in the same cycle as a resume.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    XM_SINGLE = 2'b00,
    XM_BURST  = 2'b01,
    XM_BLOCK  = 2'b10
  } xfer_mode_e;
endpackage

// File: rtl/dmaarb_chan.sv
module dmaarb_chan
  import dmaarb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              owner_i,
  input  logic              cyc_done_i,
  input  logic              cnt_done_i,
  input  logic              blk_end_i,
  input  logic              we_i,
  input  logic              en_wr_i,
  input  logic              act_wr_i,
  input  logic              ie_wr_i,
  output logic              elig_o,
  output logic              release_o,
  output logic              ending_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic en_q, act_q, ie_q, flag_q, stop_q;
  logic stop_wr, resume, cyc_end, halt_now, cnt_end, set_flag, hold_mode;
  xfer_mode_e mode;

  assign mode     = xfer_mode_e'(mode_i);
  assign stop_wr  = we_i & ~act_wr_i;
  assign resume   = we_i & en_wr_i & act_wr_i;
  assign cyc_end  = owner_i & cyc_done_i;
  assign halt_now = cyc_end & (stop_q | stop_wr);
  assign cnt_end  = cyc_end & cnt_done_i;
  assign ending_o = halt_now | cnt_end;
  assign set_flag = ending_o | (stop_wr & ~owner_i);

  always_comb begin
    case (mode)
      XM_BURST: hold_mode = 1'b1;
      XM_BLOCK: hold_mode = ~blk_end_i;
      default:  hold_mode = 1'b0;
    endcase
  end

  assign release_o = cyc_end & (ending_o | ~hold_mode);
  assign elig_o    = req_i & en_q & act_q & ~flag_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (we_i) begin
        en_q  <= en_wr_i;
        act_q <= act_wr_i;
        ie_q  <= ie_wr_i;
      end
      if (resume)        flag_q <= 1'b0;
      else if (set_flag) flag_q <= 1'b1;
      if (halt_now || resume || !owner_i) stop_q <= 1'b0;
      else if (stop_wr)                   stop_q <= 1'b1;
    end
  end

  // R5
  cnt_end_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_i && cyc_done_i && cnt_done_i && !we_i) |=> flag_o);
  // R8
  resume_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && en_wr_i && act_wr_i) |=> (!flag_o && !irq_o));
  // R7
  stop_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_i && !cyc_done_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/dmaarb_core.sv
module dmaarb_core #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] release_i,
  input  logic [NCH-1:0] ending_i,
  input  logic           ext_req_i,
  output logic [NCH-1:0] gnt_o,
  output logic           ext_gnt_o
);
  logic [NCH-1:0] gnt_q, last_q, gnt_d, pool, excl, others, pick;
  logic           ext_q, ext_d, busy, free;

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  assign busy   = |gnt_q;
  assign free   = !busy || (|(gnt_q & release_i));
  assign pool   = elig_i & ~ending_i;
  assign excl   = busy ? gnt_q : (ext_q ? last_q : '0);
  assign others = pool & ~excl;
  assign pick   = (|others) ? lowest(others) : lowest(pool);

  always_comb begin
    gnt_d = gnt_q;
    ext_d = 1'b0;
    if (free) begin
      if (ext_req_i && !ext_q) begin
        gnt_d = '0;
        ext_d = 1'b1;
      end else begin
        gnt_d = pick;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      ext_q  <= 1'b0;
      last_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      ext_q <= ext_d;
      if (busy) last_q <= gnt_q;
    end
  end

  assign gnt_o     = gnt_q;
  assign ext_gnt_o = ext_q;

  // R10
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_q, ext_q}));
  // R4
  hold_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !(|(gnt_q & release_i))) |=> $stable(gnt_o));
  // R3
  ext_one_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |=> !ext_q);
  // R11
  no_inelig_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free && !(|pool)) |=> (gnt_o == '0));
endmodule

// File: rtl/dma2_arbiter.sv
module dma2_arbiter
  import dmaarb_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        req_i,
  input  logic [NCH*MODE_W-1:0] mode_i,
  input  logic                  ext_req_i,
  input  logic [NCH-1:0]        cyc_done_i,
  input  logic [NCH-1:0]        cnt_done_i,
  input  logic [NCH-1:0]        blk_end_i,
  input  logic [NCH-1:0]        cfg_we_i,
  input  logic [NCH-1:0]        cfg_en_i,
  input  logic [NCH-1:0]        cfg_act_i,
  input  logic [NCH-1:0]        cfg_ie_i,
  output logic [NCH-1:0]        gnt_o,
  output logic                  ext_gnt_o,
  output logic [NCH-1:0]        end_flag_o,
  output logic [NCH-1:0]        irq_o
);
  logic [NCH-1:0] elig, rel, ending, gnt;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dmaarb_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i[k]),
      .mode_i     (mode_i[k*MODE_W +: MODE_W]),
      .owner_i    (gnt[k]),
      .cyc_done_i (cyc_done_i[k]),
      .cnt_done_i (cnt_done_i[k]),
      .blk_end_i  (blk_end_i[k]),
      .we_i       (cfg_we_i[k]),
      .en_wr_i    (cfg_en_i[k]),
      .act_wr_i   (cfg_act_i[k]),
      .ie_wr_i    (cfg_ie_i[k]),
      .elig_o     (elig[k]),
      .release_o  (rel[k]),
      .ending_o   (ending[k]),
      .flag_o     (end_flag_o[k]),
      .irq_o      (irq_o[k])
    );
  end

  dmaarb_core #(.NCH(NCH)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .elig_i    (elig),
    .release_i (rel),
    .ending_i  (ending),
    .ext_req_i (ext_req_i),
    .gnt_o     (gnt),
    .ext_gnt_o (ext_gnt_o)
  );

  assign gnt_o = gnt;
endmodule

// File: tb/dma2_arbiter_tb.sv
module dma2_arbiter_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] req = '0, cyc = '0, cnt = '0, blk = '0, we = '0, en = '0, act = '0, ie = '0;
  logic [3:0] mode = '0;
  logic ext = 1'b0;
  logic [1:0] gnt, flag, irq;
  logic ext_gnt;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; int sel; int exp; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  dma2_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .mode_i(mode), .ext_req_i(ext),
    .cyc_done_i(cyc), .cnt_done_i(cnt), .blk_end_i(blk), .cfg_we_i(we),
    .cfg_en_i(en), .cfg_act_i(act), .cfg_ie_i(ie), .gnt_o(gnt),
    .ext_gnt_o(ext_gnt), .end_flag_o(flag), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // sel: 0 gnt, 1 ext grant, 2 flags, 3 irq
  task automatic expect_it(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int actv;
      it = q.pop_front();
      case (it.sel)
        0: actv = int'(gnt);
        1: actv = int'(ext_gnt);
        2: actv = int'(flag);
        default: actv = int'(irq);
      endcase
      checks++;
      if (actv != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, actv, it.exp);
      end
    end
  end

  task automatic cfg(logic [1:0] w, logic [1:0] e, logic [1:0] a, logic [1:0] i);
    we = w; en = e; act = a; ie = i;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
    // R12
    expect_it("R12", 0, 0); expect_it("R12", 1, 0);
    expect_it("R12", 2, 0); expect_it("R12", 3, 0);
    cfg(2'b11, 2'b11, 2'b11, 2'b11); tick(); we = '0;
    expect_it("R11", 0, 0);
    req = 2'b11; tick();
    expect_it("R1", 0, 1);
    cyc = 2'b01; tick(); cyc = '0;
    expect_it("R9", 0, 2);
    cyc = 2'b10; ext = 1'b1; tick(); cyc = '0; ext = 1'b0;
    expect_it("R3", 1, 1); expect_it("R3", 0, 0);
    tick();
    expect_it("R3", 1, 0); expect_it("R2", 0, 1);
    req = 2'b10; mode = 4'b0100; cyc = 2'b01; tick(); cyc = '0;
    expect_it("R2", 0, 2);
    req = 2'b11; cyc = 2'b10; tick(); cyc = '0;
    expect_it("R4", 0, 2);
    cyc = 2'b10; cnt = 2'b10; tick(); cyc = '0; cnt = '0;
    expect_it("R5", 2, 2); expect_it("R6", 3, 2); expect_it("R2", 0, 1);
    cfg(2'b01, 2'b01, 2'b00, 2'b00); tick(); we = '0;
    expect_it("R7", 2, 2); expect_it("R7", 0, 1);
    cyc = 2'b01; tick(); cyc = '0;
    expect_it("R7", 2, 3); expect_it("R6", 3, 2); expect_it("R11", 0, 0);
    cfg(2'b10, 2'b10, 2'b10, 2'b10); mode = 4'b0000; tick(); we = '0;
    expect_it("R8", 2, 1); expect_it("R8", 3, 0); expect_it("R11", 0, 0);
    tick();
    expect_it("R8", 0, 2);
    cfg(2'b01, 2'b01, 2'b01, 2'b01); mode = 4'b1000; tick(); we = '0;
    expect_it("R8", 2, 0); expect_it("R10", 0, 2);
    cyc = 2'b10; tick();
    expect_it("R4", 0, 2);
    blk = 2'b10; tick(); cyc = '0; blk = '0;
    expect_it("R4", 0, 1);
    cfg(2'b10, 2'b00, 2'b10, 2'b10); tick(); we = '0;
    expect_it("R10", 0, 1);
    cyc = 2'b01; tick(); cyc = '0;
    expect_it("R11", 0, 1); expect_it("R11", 2, 0);
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule